// File: doc/BRIEF.md
# Three-Wire Serial Command Receiver

This block receives write-only register commands from a slow three-wire serial bus. The bus has a shift clock, a data line and a latch line. All three lines are brought into the fast system clock domain through multi-flop synchronizers, and their edges are detected in that domain.

Each rising edge of the shift clock shifts one data bit into a 16-bit word, most significant bit first. A rising edge of the latch line commits the word. The upper seven bits of the word become a register address and the lower nine bits become register data. Both are presented to a register file together with a write strobe that lasts one system clock.

A latch edge that follows fewer than sixteen shifted bits writes nothing. It raises a one-cycle error pulse instead. When more than sixteen bits arrive, only the last sixteen are kept.

Top module: `serial_cmd_rx`

## Requirements
- R1: While reset is held and immediately after it, `wr_en_o` and `frame_err_o` are low, and `wr_addr_o` and `wr_data_o` are zero.
- R2: A data bit is taken only on a rising edge of `ser_clk_i`, with the first bit shifted landing in word bit 15 and the last in word bit 0. The level of `ser_data_i` around a falling edge of the shift clock has no effect on the word.
- R3: On a write, `wr_addr_o` equals word bits 15 down to 9.
- R4: On a write, `wr_data_o` equals word bits 8 down to 0.
- R5: Each rising edge of `ser_latch_i` that comes after at least 16 shift-clock rising edges since the previous latch rising edge produces exactly one `wr_en_o` pulse, one system clock long.
- R6: A rising edge of `ser_latch_i` that comes after 0 to 15 shift-clock rising edges since the previous latch rising edge produces one `frame_err_o` pulse, one system clock long. It produces no `wr_en_o` pulse, and `wr_addr_o` and `wr_data_o` keep their previous values.
- R7: When more than 16 bits are shifted before a latch edge, the word committed is made of the last 16 bits shifted.
- R8: Only the rising edge of `ser_latch_i` acts. Holding the latch high while bits are shifted, or letting it fall, commits nothing. Every latch rising edge restarts the bit count from zero.
- R9: Between writes, `wr_addr_o` and `wr_data_o` hold the values of the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_latch_i | input | 1 | Serial latch line (asynchronous, rising edge commits) |
| ser_data_i | input | 1 | Serial data line (asynchronous) |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address of the last write |
| wr_data_o | output | 9 | Register data of the last write |
| frame_err_o | output | 1 | One-cycle pulse on a short word |

## Verification
The assertions take two things for granted.

- The serial lines change slowly compared with the system clock, so a synchronized latch rising edge can never follow another within one system cycle.
- The data line is steady for several system clocks on each side of a shift-clock rising edge, so the synchronized data bit lines up with the synchronized edge.

The stimulus keeps each serial phase four system clocks long. It changes the data line only four clocks after a shift-clock rise, which is still before the fall. It also never moves the latch line in the same window as the shift clock.

// File: rtl/serial_cmd_pkg.sv
// Package: shared sizing for the serial command receiver.
// Assumes the word splits into an address field on top and a data field below.
package serial_cmd_pkg;
    parameter int WORD_W      = 16;
    parameter int ADDR_W      = 7;
    parameter int SYNC_STAGES = 2;
    localparam int DATA_W     = WORD_W - ADDR_W;
    localparam int CNT_W      = $clog2(WORD_W + 1);

    // Edge information produced for one synchronized line
    typedef struct packed {
        logic level;
        logic rise;
    } line_state_t;
endpackage

// File: rtl/bit_sync.sv
// Module: bit_sync
// Multi-flop synchronizer bringing one asynchronous line into clk.
// Assumes STAGES >= 2. The reset value of every stage is 0.
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sync_edge.sv
// Module: sync_edge
// Synchronizes one line and flags its rising edge for one clk cycle.
// Assumes the line stays in each state for at least two clk cycles.
module sync_edge
    import serial_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        d_i,
    output line_state_t st_o
);
    logic lvl;
    logic lvl_d;

    bit_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (d_i),
        .q_o  (lvl)
    );

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign st_o.level = lvl;
    assign st_o.rise  = lvl & ~lvl_d;

    // A rising edge cannot repeat on consecutive cycles
    assert_rise_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_o.rise |=> !st_o.rise);
endmodule

// File: rtl/cmd_shifter.sv
// Module: cmd_shifter
// Shift register with a saturating bit counter for the serial word.
// A bit arriving in the same cycle as a commit counts toward that commit.
// The counter restarts at zero after every commit.
module cmd_shifter
    import serial_cmd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         commit_i,
    output logic [W-1:0] word_o,
    output logic         full_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  sr_q,  sr_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    // Next word and next count, including a bit arriving this cycle
    always_comb begin
        sr_nx  = sr_q;
        cnt_nx = cnt_q;
        if (shift_i) begin
            sr_nx  = {sr_q[W-2:0], bit_i};
            cnt_nx = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
        end
    end

    // Hold the word and count, clearing the count at each commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            sr_q  <= sr_nx;
            cnt_q <= commit_i ? '0 : cnt_nx;
        end
    end

    assign word_o = sr_nx;
    assign full_o = (cnt_nx == FULL);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    assert_count_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (cnt_q == '0));
endmodule

// File: rtl/cmd_commit.sv
// Module: cmd_commit
// Turns a commit request into a registered write or an error pulse.
// Assumes a commit request never repeats on consecutive cycles.
module cmd_commit
    import serial_cmd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic             full_i,
    input  logic [AW+DW-1:0] word_i,
    output logic             wr_en_o,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    data_o,
    output logic             err_o
);
    // Register the strobe, the split fields and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o <= 1'b0;
            err_o   <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
        end else begin
            wr_en_o <= commit_i & full_i;
            err_o   <= commit_i & ~full_i;
            if (commit_i && full_i) begin
                addr_o <= word_i[AW+DW-1:DW];
                data_o <= word_i[DW-1:0];
            end
        end
    end

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && err_o));
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> $stable(addr_o));
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> $stable(data_o));
endmodule

// File: rtl/serial_cmd_rx.sv
// Module: serial_cmd_rx
// Top of the three-wire write-only command receiver.
// Assumes the serial lines are much slower than clk. The latch rising edge
// commits the last WORD_W bits as {address, data}.
module serial_cmd_rx
    import serial_cmd_pkg::*;
#(
    parameter int W_WORD  = WORD_W,
    parameter int W_ADDR  = ADDR_W,
    parameter int NSTAGES = SYNC_STAGES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk_i,
    input  logic                     ser_latch_i,
    input  logic                     ser_data_i,
    output logic                     wr_en_o,
    output logic [W_ADDR-1:0]        wr_addr_o,
    output logic [W_WORD-W_ADDR-1:0] wr_data_o,
    output logic                     frame_err_o
);
    localparam int W_DATA = W_WORD - W_ADDR;

    line_state_t      sclk_st, latch_st;
    logic             data_s;
    logic [W_WORD-1:0] word;
    logic             full;

    sync_edge #(.STAGES(NSTAGES)) u_sclk (
        .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .st_o(sclk_st)
    );
    sync_edge #(.STAGES(NSTAGES)) u_latch (
        .clk(clk), .rst_n(rst_n), .d_i(ser_latch_i), .st_o(latch_st)
    );
    bit_sync #(.STAGES(NSTAGES)) u_data (
        .clk(clk), .rst_n(rst_n), .d_i(ser_data_i), .q_o(data_s)
    );

    cmd_shifter #(.W(W_WORD)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sclk_st.rise),
        .bit_i   (data_s),
        .commit_i(latch_st.rise),
        .word_o  (word),
        .full_o  (full)
    );

    cmd_commit #(.AW(W_ADDR), .DW(W_DATA)) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(latch_st.rise),
        .full_i  (full),
        .word_i  (word),
        .wr_en_o (wr_en_o),
        .addr_o  (wr_addr_o),
        .data_o  (wr_data_o),
        .err_o   (frame_err_o)
    );

    assert_write_on_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(latch_st.rise));
    assert_err_on_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> $past(latch_st.rise));
endmodule

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, slat = 1'b0, sdat = 1'b0;
    logic wr_en, ferr;
    logic [6:0] waddr;
    logic [8:0] wdata;

    int checks = 0, errors = 0, cycles = 0;
    int wr_seen = 0, err_seen = 0;
    int got_a = 0, got_d = 0;

    always #2 clk = ~clk;

    serial_cmd_rx uut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_latch_i(slat), .ser_data_i(sdat),
        .wr_en_o(wr_en), .wr_addr_o(waddr), .wr_data_o(wdata),
        .frame_err_o(ferr)
    );

    // Monitor: count strobes and capture the fields seen with each write
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (wr_en) begin
                wr_seen++;
                got_a = int'(waddr);
                got_d = int'(wdata);
            end
            if (ferr) err_seen++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit: data flips to the opposite value between rise and fall
    task automatic shift_bit(input logic b);
        sdat = b;     wait_clk(4);
        sclk = 1'b1;  wait_clk(4);
        sdat = ~b;    wait_clk(4);
        sclk = 1'b0;  wait_clk(4);
    endtask

    task automatic latch_pulse();
        slat = 1'b1; wait_clk(6);
        slat = 1'b0; wait_clk(10);
    endtask

    // Shift n bits: the low min(n,16) bits of w MSB-first, preceded by junk
    task automatic send(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--)
            shift_bit((i < 16) ? w[i] : logic'(i % 3 == 0));
    endtask

    task automatic expect_write(input logic [15:0] w, input int wr0, input int er0, input string req);
        check(wr_seen == wr0 + 1, {req, " write count"}, wr_seen, wr0 + 1);
        check(err_seen == er0, {req, " no error"}, err_seen, er0);
        check(got_a == int'(w[15:9]), {req, " R3 address"}, got_a, int'(w[15:9]));
        check(got_d == int'(w[8:0]), {req, " R4 data"}, got_d, int'(w[8:0]));
        check(waddr == w[15:9] && wdata == w[8:0], {req, " R9 held"},
              int'({waddr, wdata}), int'(w));
    endtask

    task automatic frame(input logic [15:0] w, input int n);
        int wr0, er0;
        wr0 = wr_seen; er0 = err_seen;
        send(w, n);
        latch_pulse();
        if (n >= 16) expect_write(w, wr0, er0, (n > 16) ? "R7" : "R5");
    endtask

    // Watchdog
    initial begin
        wait (cycles > 190000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] last;
        wait_clk(3);
        // R1: reset state
        check(!wr_en && !ferr && waddr == 0 && wdata == 0, "R1 during reset",
              int'({wr_en, ferr, waddr, wdata}), 0);
        rst_n = 1'b1;
        wait_clk(2);
        check(!wr_en && !ferr && waddr == 0 && wdata == 0, "R1 after reset",
              int'({wr_en, ferr, waddr, wdata}), 0);

        // R2/R3/R5: sweep every address with arithmetic data
        for (int a = 0; a < 128; a++) begin
            last = {7'(a), 9'((a * 37 + 5) % 512)};
            frame(last, 16);
        end
        // R4: walking-one data, plus all-zero and all-one data
        for (int b = 0; b < 9; b++) begin
            last = {7'h55, 9'(1 << b)};
            frame(last, 16);
        end
        last = 16'h0000; frame(last, 16);
        last = 16'hFFFF; frame(last, 16);
        last = 16'hA3C5; frame(last, 16);   // R2 MSB-first asymmetric pattern

        // R6: short words 0..15 give an error, no write, outputs held
        for (int n = 0; n < 16; n++) begin
            int wr0, er0;
            wr0 = wr_seen; er0 = err_seen;
            send(16'h5A5A, n);
            latch_pulse();
            check(err_seen == er0 + 1, "R6 error pulse", err_seen, er0 + 1);
            check(wr_seen == wr0, "R6 no write", wr_seen, wr0);
            check(waddr == last[15:9] && wdata == last[8:0], "R6 outputs held",
                  int'({waddr, wdata}), int'(last));
        end

        // R7: extra leading bits are discarded
        for (int n = 17; n <= 24; n++) begin
            last = 16'((n * 4099 + 321) % 65536);
            frame(last, n);
        end

        // R8: latch held high while shifting, falling edge commits nothing
        begin
            logic [15:0] w1, w2;
            int wr0, er0;
            w1 = 16'h3E17; w2 = 16'hC1E8;
            wr0 = wr_seen; er0 = err_seen;
            send(w1, 16);
            slat = 1'b1; wait_clk(10);
            expect_write(w1, wr0, er0, "R8 first edge");
            send(w2, 16);
            slat = 1'b0; wait_clk(10);
            check(wr_seen == wr0 + 1, "R8 fall no write", wr_seen, wr0 + 1);
            check(err_seen == er0, "R8 fall no error", err_seen, er0);
            check(waddr == w1[15:9] && wdata == w1[8:0], "R8 held after fall",
                  int'({waddr, wdata}), int'(w1));
            slat = 1'b1; wait_clk(10);
            expect_write(w2, wr0 + 1, er0, "R8 second edge");
            slat = 1'b0; wait_clk(10);
            // Count restarted: an immediate latch edge is a short word
            wr0 = wr_seen; er0 = err_seen;
            latch_pulse();
            check(err_seen == er0 + 1, "R8 count restart", err_seen, er0 + 1);
            check(wr_seen == wr0, "R8 count restart no write", wr_seen, wr0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule